// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection and Low-Power Output Overrides

This block is one bank of sixteen general-purpose pins. Each pin can be a plain input or a driven output. Each pin also has its own interrupt detector, which is set up for either edge or level sensing in either polarity. Pad inputs are resynchronised before any use. Detected events are latched into a status register, and software clears a bit by writing 1 to it. The bank interrupt line is raised whenever a latched event is not masked.

Each pin has two further output values. One applies while the system is in sleep and the other during a battery fault. When both conditions hold, the battery-fault value wins. The sleep override and the separate sleep interrupt mask take effect only when the automatic-sleep bit of the sleep configuration register is set. An alternate-function select register is brought out so that a neighbouring multiplexer can hand pins to other peripherals.

Registers sit at word offsets on a simple single-cycle write port. The read data is combinational from the offset.

Top module: `gpio_bank`

## Requirements
- R1: While reset is held, the interrupt mask (0x00) and the sleep mask (0x18) read 0xFFFF and every other register reads 0. While reset is held, `pad_oe`, `pad_out`, `alt_sel` and `irq` are 0.
- R2: The following registers read back the value last written, all 16 bits:
  - 0x00 mask
  - 0x04 direction
  - 0x08 output
  - 0x0C trigger type
  - 0x10 edge select
  - 0x14 level select
  - 0x18 sleep mask
  - 0x1C sleep output
  - 0x20 battery-fault output
  - 0x28 alternate function
- R2 (continued): The sleep configuration register at 0x2C keeps only bit 1. Offset 0x30 is read-only, and a write to it has no effect. Unmapped offsets read 0.
- R3: `pad_oe` equals the direction register, where 1 means output. With no override active, `pad_out` equals the output register.
- R4: `pad_out` bit i takes its value in this order of priority:
  - the battery-fault output bit, when `batt_fault` is 1;
  - otherwise the sleep output bit, when `sleep_mode` is 1 and sleep configuration bit 1 is 1;
  - otherwise the output register bit.
- R5: Offset 0x30 returns the pad inputs through a two-stage synchroniser. A pad change made before a clock edge is visible after the second edge, counting that edge as the first.
- R6: With trigger type bit = 1 (edge), the pin detects on an edge:
  - with edge select = 1 it detects a rising edge, and with edge select = 0 a falling edge;
  - the status bit (0x24) is 1 after the third clock edge following the pad change, and still 0 after the second;
  - the opposite edge does not set it.
- R7: With trigger type bit = 0 (level), the pin detects on a level:
  - with level select = 1 it detects a high level, and with level select = 0 a low level;
  - the status bit sets while the synchronised level matches.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a detection occurs in the same cycle as the clear, the bit stays 1.
- R9: `irq` is 1 exactly when some status bit is 1 and its effective mask bit is 0. The effective mask is the sleep mask while the sleep override of R4 is active, and the mask register otherwise. Status bits set even when masked.
- R10: `alt_sel` equals the alternate-function register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| alt_sel | output | 16 | Alternate-function select per pin |
| sleep_mode | input | 1 | System sleep indication |
| batt_fault | input | 1 | Battery-fault indication |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest case to produce from the ports is a clear that collides with a new detection on the same bit. Pulses alone rarely line up in the same cycle. The bench holds a pin at its selected level in level mode, so a fresh detection is present in every cycle. It then writes 1 to that status bit and checks that the bit still reads 1. Edge timing is pinned by sampling the status after the second and third edges that follow each single-pin toggle, for every pin and both polarities.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int OFS_W = 6;
  localparam logic [OFS_W-1:0] OFS_MASK   = 6'h00;
  localparam logic [OFS_W-1:0] OFS_DIR    = 6'h04;
  localparam logic [OFS_W-1:0] OFS_OUT    = 6'h08;
  localparam logic [OFS_W-1:0] OFS_TRIG   = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_EDGE   = 6'h10;
  localparam logic [OFS_W-1:0] OFS_LVL    = 6'h14;
  localparam logic [OFS_W-1:0] OFS_SMASK  = 6'h18;
  localparam logic [OFS_W-1:0] OFS_SOUT   = 6'h1C;
  localparam logic [OFS_W-1:0] OFS_BFOUT  = 6'h20;
  localparam logic [OFS_W-1:0] OFS_STAT   = 6'h24;
  localparam logic [OFS_W-1:0] OFS_ALT    = 6'h28;
  localparam logic [OFS_W-1:0] OFS_SCFG   = 6'h2C;
  localparam logic [OFS_W-1:0] OFS_PINS   = 6'h30;
  localparam int SCFG_AUTO_BIT = 1;

  // Detection for one pin: edge mode compares current and previous samples.
  function automatic logic pin_event(logic cur, logic prev, logic is_edge,
                                     logic rise, logic high);
    if (is_edge) return rise ? (cur & ~prev) : (~cur & prev);
    return cur == high;
  endfunction

  // Output choice for one pin: battery fault over sleep over normal.
  function automatic logic pin_drive(logic norm, logic slp, logic bf,
                                     logic sleep_act, logic batt);
    if (batt) return bf;
    if (sleep_act) return slp;
    return norm;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect import gpio_bank_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] trig_edge,
  input  logic [W-1:0] edge_rise,
  input  logic [W-1:0] lvl_high,
  input  logic [W-1:0] clr,
  output logic [W-1:0] evt,
  output logic [W-1:0] stat
);
  logic [W-1:0] prev_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      assign evt[i] = pin_event(pin_sync[i], prev_q[i], trig_edge[i],
                                edge_rise[i], lvl_high[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat   <= '0;
    end else begin
      prev_q <= pin_sync;
      stat   <= (stat & ~clr) | evt;
    end
  end
endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux import gpio_bank_pkg::*; #(
  parameter int W = 16
) (
  input  logic [W-1:0] norm,
  input  logic [W-1:0] slp,
  input  logic [W-1:0] bf,
  input  logic         sleep_act,
  input  logic         batt,
  output logic [W-1:0] drive
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      assign drive[i] = pin_drive(norm[i], slp[i], bf[i], sleep_act, batt);
    end
  endgenerate
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank import gpio_bank_pkg::*; #(
  parameter int PINS        = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PINS-1:0]   reg_wdata,
  output logic [PINS-1:0]   reg_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   alt_sel,
  input  logic              sleep_mode,
  input  logic              batt_fault,
  output logic              irq
);
  logic [PINS-1:0] mask_q, dir_q, out_q, trig_q, edge_q, lvl_q;
  logic [PINS-1:0] smask_q, sout_q, bf_q, alt_q;
  logic            auto_q;
  logic [PINS-1:0] pin_sync, evt, stat_q, clr, eff_mask;
  logic            sleep_act;
  logic            stat_wr;

  assign stat_wr = reg_wr && (reg_addr == ADDR_W'(OFS_STAT));
  assign clr     = stat_wr ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      smask_q <= '1;
      dir_q   <= '0;
      out_q   <= '0;
      trig_q  <= '0;
      edge_q  <= '0;
      lvl_q   <= '0;
      sout_q  <= '0;
      bf_q    <= '0;
      alt_q   <= '0;
      auto_q  <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_W'(OFS_MASK):  mask_q  <= reg_wdata;
        ADDR_W'(OFS_DIR):   dir_q   <= reg_wdata;
        ADDR_W'(OFS_OUT):   out_q   <= reg_wdata;
        ADDR_W'(OFS_TRIG):  trig_q  <= reg_wdata;
        ADDR_W'(OFS_EDGE):  edge_q  <= reg_wdata;
        ADDR_W'(OFS_LVL):   lvl_q   <= reg_wdata;
        ADDR_W'(OFS_SMASK): smask_q <= reg_wdata;
        ADDR_W'(OFS_SOUT):  sout_q  <= reg_wdata;
        ADDR_W'(OFS_BFOUT): bf_q    <= reg_wdata;
        ADDR_W'(OFS_ALT):   alt_q   <= reg_wdata;
        ADDR_W'(OFS_SCFG):  auto_q  <= reg_wdata[SCFG_AUTO_BIT];
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_evt_detect #(.W(PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .trig_edge(trig_q),
    .edge_rise(edge_q), .lvl_high(lvl_q), .clr(clr), .evt(evt), .stat(stat_q)
  );

  assign sleep_act = sleep_mode & auto_q;

  gpio_out_mux #(.W(PINS)) u_mux (
    .norm(out_q), .slp(sout_q), .bf(bf_q), .sleep_act(sleep_act),
    .batt(batt_fault), .drive(pad_out)
  );

  assign pad_oe   = dir_q;
  assign alt_sel  = alt_q;
  assign eff_mask = sleep_act ? smask_q : mask_q;
  assign irq      = |(stat_q & ~eff_mask);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_MASK):  reg_rdata = mask_q;
      ADDR_W'(OFS_DIR):   reg_rdata = dir_q;
      ADDR_W'(OFS_OUT):   reg_rdata = out_q;
      ADDR_W'(OFS_TRIG):  reg_rdata = trig_q;
      ADDR_W'(OFS_EDGE):  reg_rdata = edge_q;
      ADDR_W'(OFS_LVL):   reg_rdata = lvl_q;
      ADDR_W'(OFS_SMASK): reg_rdata = smask_q;
      ADDR_W'(OFS_SOUT):  reg_rdata = sout_q;
      ADDR_W'(OFS_BFOUT): reg_rdata = bf_q;
      ADDR_W'(OFS_STAT):  reg_rdata = stat_q;
      ADDR_W'(OFS_ALT):   reg_rdata = alt_q;
      ADDR_W'(OFS_SCFG):  reg_rdata[SCFG_AUTO_BIT] = auto_q;
      ADDR_W'(OFS_PINS):  reg_rdata = pin_sync;
      default:            reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk import gpio_bank_pkg::*; #(
  parameter int PINS   = 16,
  parameter int ADDR_W = OFS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [PINS-1:0]   reg_wdata,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   pad_out,
  input logic              batt_fault,
  input logic [PINS-1:0]   bf_q,
  input logic [PINS-1:0]   evt,
  input logic [PINS-1:0]   stat_q,
  input logic              irq
);
  p_oe_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_DIR)) |=> (pad_oe == $past(reg_wdata)));

  p_batt_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    batt_fault |-> (pad_out == bf_q));

  p_stat_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_STAT))
      |=> ((stat_q & $past(reg_wdata & ~evt)) == '0));

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0));
endmodule

bind gpio_bank gpio_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pad_oe(pad_oe), .pad_out(pad_out),
  .batt_fault(batt_fault), .bf_q(bf_q), .evt(evt), .stat_q(stat_q), .irq(irq)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [5:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic [15:0] pad_in = 0;
  logic [15:0] pad_out, pad_oe, alt_sel;
  logic        sleep_mode = 0, batt_fault = 0;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel),
    .sleep_mode(sleep_mode), .batt_fault(batt_fault), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(string req, logic [5:0] a, logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pads(logic [15:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [4] = '{16'hA5C3, 16'h5A3C, 16'hFFFF, 16'h0000};
    logic [5:0]  rw_ofs [10] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10,
                                 6'h14, 6'h18, 6'h1C, 6'h20, 6'h28};
    logic [15:0] st;
    // R1: reset values while reset is held
    repeat (3) @(negedge clk);
    for (int k = 0; k < 13; k++)
      rd("R1", 6'(k * 4), (k == 0 || k == 6) ? 16'hFFFF : 16'h0000);
    chk("R1", pad_oe, 0); chk("R1", pad_out, 0); chk("R1", alt_sel, 0);
    chk("R1", {15'd0, irq}, 0);
    @(negedge clk); rst_n = 1;

    // R2: readback sweep
    foreach (pats[p]) foreach (rw_ofs[o]) begin
      wr(rw_ofs[o], pats[p]);
      rd("R2", rw_ofs[o], pats[p]);
    end
    wr(6'h2C, 16'hFFFF); rd("R2", 6'h2C, 16'h0002);
    wr(6'h2C, 16'h0000); rd("R2", 6'h2C, 16'h0000);
    rd("R2", 6'h34, 0); rd("R2", 6'h3C, 0);
    set_pads(16'h1234); tick(3);
    wr(6'h30, 16'hFFFF); rd("R2", 6'h30, 16'h1234);

    // R10
    wr(6'h28, 16'h1357); chk("R10", alt_sel, 16'h1357);

    // R3
    foreach (pats[p]) begin
      wr(6'h04, pats[p]); wr(6'h08, ~pats[p]);
      chk("R3", pad_oe, pats[p]); chk("R3", pad_out, ~pats[p]);
    end

    // R4: priority sweep
    wr(6'h08, 16'hA5A5); wr(6'h1C, 16'h3C3C); wr(6'h20, 16'hF00F);
    for (int c = 0; c < 2; c++) begin
      wr(6'h2C, c ? 16'h0002 : 16'h0000);
      for (int b = 0; b < 2; b++) for (int s = 0; s < 2; s++) begin
        @(negedge clk); batt_fault = b[0]; sleep_mode = s[0]; #1;
        chk("R4", pad_out, b ? 16'hF00F : ((s && c) ? 16'h3C3C : 16'hA5A5));
      end
    end
    @(negedge clk); batt_fault = 0; sleep_mode = 0;
    wr(6'h2C, 0);

    // R5: synchroniser latency
    set_pads(16'h0000); tick(3);
    set_pads(16'hBEEF); tick(1); rd("R5", 6'h30, 16'h0000);
    tick(1); rd("R5", 6'h30, 16'hBEEF);

    // R6: rising edges, every pin
    wr(6'h00, 16'hFFFF);
    wr(6'h0C, 16'hFFFF); wr(6'h10, 16'hFFFF);
    set_pads(0); tick(4); wr(6'h24, 16'hFFFF);
    for (int i = 0; i < 16; i++) begin
      set_pads(16'(1 << i)); tick(2); rd("R6", 6'h24, 0);
      tick(1); rd("R6", 6'h24, 16'(1 << i));
      wr(6'h24, 16'hFFFF);
      set_pads(0); tick(4); rd("R6", 6'h24, 0);
    end
    // R6: falling edges, every pin
    wr(6'h10, 16'h0000);
    set_pads(16'hFFFF); tick(4); wr(6'h24, 16'hFFFF);
    for (int i = 0; i < 16; i++) begin
      set_pads(~16'(1 << i)); tick(2); rd("R6", 6'h24, 0);
      tick(1); rd("R6", 6'h24, 16'(1 << i));
      wr(6'h24, 16'hFFFF);
      set_pads(16'hFFFF); tick(4); rd("R6", 6'h24, 0);
    end

    // R7: level high then level low
    wr(6'h0C, 0); wr(6'h14, 16'hFFFF);
    set_pads(0); tick(4); wr(6'h24, 16'hFFFF); tick(1);
    rd("R7", 6'h24, 0);
    set_pads(16'h00F0); tick(3); rd("R7", 6'h24, 16'h00F0);
    // R8: clear collides with a persisting level detection
    wr(6'h24, 16'h00F0); rd("R8", 6'h24, 16'h00F0);
    set_pads(0); tick(3); wr(6'h24, 16'hFFFF); rd("R8", 6'h24, 0);
    wr(6'h14, 0); set_pads(16'hFFFF); tick(4); wr(6'h24, 16'hFFFF); tick(1);
    rd("R7", 6'h24, 0);
    set_pads(16'h0F0F); tick(3); rd("R7", 6'h24, 16'hF0F0);

    // R8: clear in edge mode
    wr(6'h0C, 16'hFFFF); wr(6'h10, 16'hFFFF);
    set_pads(0); tick(4); wr(6'h24, 16'hFFFF);
    set_pads(16'hFFFF); tick(3); rd("R8", 6'h24, 16'hFFFF);
    wr(6'h24, 16'h00FF); rd("R8", 6'h24, 16'hFF00);
    wr(6'h24, 16'h0000); rd("R8", 6'h24, 16'hFF00);

    // R9: masks (status was set under a full mask)
    st = 16'hFF00;
    chk("R9", {15'd0, irq}, 0);
    for (int i = 0; i < 16; i++) begin
      wr(6'h00, ~16'(1 << i));
      chk("R9", {15'd0, irq}, {15'd0, st[i]});
    end
    wr(6'h00, 16'hFFFF);
    wr(6'h2C, 16'h0002);
    @(negedge clk); sleep_mode = 1;
    wr(6'h18, 16'hFEFF); chk("R9", {15'd0, irq}, 1);
    wr(6'h18, 16'hFFF7); chk("R9", {15'd0, irq}, 0);
    wr(6'h18, 16'hFEFF);
    wr(6'h2C, 0); chk("R9", {15'd0, irq}, 0);
    wr(6'h00, 16'h7FFF); chk("R9", {15'd0, irq}, 1);
    @(negedge clk); sleep_mode = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule